// File: doc/BRIEF.md
# Dual-Ratio Clock Enable Prescaler

This block derives two slower rates from the main oscillator clock and presents them as single-cycle enable strobes in the oscillator domain, so that every consumer stays on one clock tree. One 8-bit control register, reached over the internal register bus, holds the ratios for both dividers. The peripheral divider offers powers of two up to 8. The prescaler divider also offers the even ratios 6, 10 and 12, up to 16.

Three control bits in the same register act on the auxiliary rate. One selects which of the two divided rates acts as the auxiliary rate. One drives a square wave at that rate onto the external clock-out pin. The third turns each auxiliary pulse into an instruction-request strobe, so that a processor core can step exactly one instruction per auxiliary period. Software writes the register once and the dividers run freely from then on. A write that changes a ratio restarts only the divider it affects.

Top module: `dual_rate_prescaler`

## Requirements
- R1: After reset the control register reads 0x00, and both `per_tick` and `psc_tick` are high in every cycle (both ratios are 1).
- R2: A write with `bus_wr` high and `bus_addr` equal to 0xF3 loads `bus_wdata` into all 8 register bits at the clock edge. `bus_rdata` shows the full register whenever `bus_addr` is 0xF3 and shows 0x00 for any other address. Writes to other addresses leave the register unchanged.
- R3: Register bits 4:3 set the peripheral ratio: 00→1, 01→2, 10→4, 11→8. `per_tick` is high for one cycle out of every ratio cycles.
- R4: Register bits 2:0 set the prescaler ratio: 000→1, 001→2, 010→4, 011→6, 100→8, 101→10, 110→12, 111→16. `psc_tick` is high for one cycle out of every ratio cycles.
- R5: With register bit 6 at 0, `aux_tick` follows `psc_tick`. With bit 6 at 1, it follows `per_tick`.
- R6: `sync_req` equals `aux_tick` while register bit 5 is 1, and is 0 while bit 5 is 0.
- R7: `clk_out` is 0 while register bit 7 is 0. While bit 7 is 1, `clk_out` is high for the first ceil(r/2) cycles of each period of the selected divider (ratio r) and low for the rest. The tick falls in the last cycle of each period, and with r = 1 the pin stays high.
- R8: A register write that changes a divider's ratio field restarts that divider. Counting the cycle after the write as cycle 1, its ticks fall in cycles r, 2r, and so on. A write that leaves a field unchanged does not disturb that divider's phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register bus address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0x00 when the address misses |
| per_tick | output | 1 | Peripheral-rate enable strobe |
| psc_tick | output | 1 | Prescaler-rate enable strobe |
| aux_tick | output | 1 | Selected auxiliary-rate strobe |
| clk_out | output | 1 | Square wave for the external clock pin |
| sync_req | output | 1 | Instruction-request strobe to the core |

## Verification
The assertions assume that the bus presents at most one write per cycle and that address and data are stable across the sampling edge. They also assume that reset is held for at least one rising edge. The bench drives every bus input at the falling edge, asserts `bus_wr` only for single cycles, and holds reset across several edges. Writes land at arbitrary divider phases, and the address alternates between the register and an unrelated address. This exercises the restart and read-mux rules without any input changing close to an active edge.

// File: rtl/dprs_pkg.sv
package dprs_pkg;

    localparam int RATIO_W = 5;   // holds ratios up to 16
    localparam int CNT_W   = 4;   // phase counter 0..15

    typedef struct packed {
        logic       pin_en;
        logic       aux_sel;
        logic       step_en;
        logic [1:0] per_code;
        logic [2:0] psc_code;
    } ctrl_t;

    function automatic logic [RATIO_W-1:0] per_ratio_of(input logic [1:0] code);
        return RATIO_W'(1) << code;
    endfunction

    function automatic logic [RATIO_W-1:0] psc_ratio_of(input logic [2:0] code);
        logic [RATIO_W-1:0] r;
        unique case (code)
            3'd0:    r = RATIO_W'(1);
            3'd1:    r = RATIO_W'(2);
            3'd2:    r = RATIO_W'(4);
            3'd3:    r = RATIO_W'(6);
            3'd4:    r = RATIO_W'(8);
            3'd5:    r = RATIO_W'(10);
            3'd6:    r = RATIO_W'(12);
            default: r = RATIO_W'(16);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dprs_ctrl_reg.sv
module dprs_ctrl_reg
    import dprs_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter logic [7:0]  REG_ADDR = 8'hF3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output ctrl_t             ctrl_q,
    output logic              per_clr,
    output logic              psc_clr
);

    logic  wr_hit;
    ctrl_t ctrl_new;

    assign wr_hit   = bus_wr && (bus_addr == ADDR_W'(REG_ADDR));
    assign ctrl_new = ctrl_t'(bus_wdata);

    // restart a divider only when its own ratio field changes
    assign per_clr = wr_hit && (ctrl_new.per_code != ctrl_q.per_code);
    assign psc_clr = wr_hit && (ctrl_new.psc_code != ctrl_q.psc_code);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_hit) begin
            ctrl_q <= ctrl_new;
        end
    end

endmodule

// File: rtl/dprs_divider.sv
module dprs_divider #(
    parameter int CNT_W   = 4,
    parameter int RATIO_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [RATIO_W-1:0] ratio,
    output logic               tick,
    output logic [CNT_W-1:0]   count
);

    logic [CNT_W-1:0] last;

    assign last = CNT_W'(ratio - RATIO_W'(1));
    assign tick = (count == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr || tick) begin
            count <= '0;
        end else begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/dual_rate_prescaler.sv
module dual_rate_prescaler
    import dprs_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter logic [7:0] REG_ADDR = 8'hF3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              per_tick,
    output logic              psc_tick,
    output logic              aux_tick,
    output logic              clk_out,
    output logic              sync_req
);

    localparam int N_DIV   = 2;
    localparam int IDX_PER = 0;
    localparam int IDX_PSC = 1;

    ctrl_t              ctrl_q;
    logic               per_clr;
    logic               psc_clr;
    logic [RATIO_W-1:0] per_ratio;
    logic [RATIO_W-1:0] psc_ratio;
    logic [RATIO_W-1:0] div_ratio [N_DIV];
    logic               div_clr   [N_DIV];
    logic               div_tick  [N_DIV];
    logic [CNT_W-1:0]   div_count [N_DIV];
    logic [RATIO_W-1:0] sel_ratio;
    logic [CNT_W-1:0]   sel_count;
    logic [RATIO_W-1:0] high_len;

    dprs_ctrl_reg #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ctrl_q    (ctrl_q),
        .per_clr   (per_clr),
        .psc_clr   (psc_clr)
    );

    assign per_ratio = per_ratio_of(ctrl_q.per_code);
    assign psc_ratio = psc_ratio_of(ctrl_q.psc_code);

    assign div_ratio[IDX_PER] = per_ratio;
    assign div_ratio[IDX_PSC] = psc_ratio;
    assign div_clr[IDX_PER]   = per_clr;
    assign div_clr[IDX_PSC]   = psc_clr;

    for (genvar g = 0; g < N_DIV; g++) begin : g_div
        dprs_divider #(
            .CNT_W   (CNT_W),
            .RATIO_W (RATIO_W)
        ) u_div (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (div_clr[g]),
            .ratio (div_ratio[g]),
            .tick  (div_tick[g]),
            .count (div_count[g])
        );
    end

    assign per_tick = div_tick[IDX_PER];
    assign psc_tick = div_tick[IDX_PSC];

    // auxiliary source selection
    always_comb begin
        if (ctrl_q.aux_sel) begin
            aux_tick  = div_tick[IDX_PER];
            sel_ratio = div_ratio[IDX_PER];
            sel_count = div_count[IDX_PER];
        end else begin
            aux_tick  = div_tick[IDX_PSC];
            sel_ratio = div_ratio[IDX_PSC];
            sel_count = div_count[IDX_PSC];
        end
    end

    // pin high for the first ceil(r/2) phases of each period
    assign high_len = (sel_ratio + RATIO_W'(1)) >> 1;
    assign clk_out  = ctrl_q.pin_en && (RATIO_W'(sel_count) < high_len);
    assign sync_req = ctrl_q.step_en && aux_tick;

    assign bus_rdata = (bus_addr == ADDR_W'(REG_ADDR)) ? 8'(ctrl_q) : 8'h00;

endmodule

// File: rtl/dprs_checker.sv
module dprs_checker #(
    parameter int         ADDR_W   = 8,
    parameter int         RATIO_W  = 5,
    parameter logic [7:0] REG_ADDR = 8'hF3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [7:0]         bus_wdata,
    input logic [7:0]         ctrl_bits,
    input logic [RATIO_W-1:0] per_ratio,
    input logic [RATIO_W-1:0] psc_ratio,
    input logic               per_clr,
    input logic               psc_clr,
    input logic               per_tick,
    input logic               psc_tick,
    input logic               aux_tick,
    input logic               clk_out,
    input logic               sync_req
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (ctrl_bits == 8'h00));  // R1

    AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(REG_ADDR)) |=> (ctrl_bits == $past(bus_wdata)));  // R2

    AST_PER_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (per_tick && per_ratio != RATIO_W'(1) && !per_clr) |=> !per_tick);  // R3

    AST_PSC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (psc_tick && psc_ratio != RATIO_W'(1) && !psc_clr) |=> !psc_tick);  // R4

    AST_AUX_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_tick && !ctrl_bits[6]) |-> psc_tick);  // R5

    AST_SYNC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        sync_req |-> (ctrl_bits[5] && aux_tick));  // R6

    AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_bits[7] |-> !clk_out);  // R7

    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        per_clr |=> (!per_tick || per_ratio == RATIO_W'(1)));  // R8

endmodule

bind dual_rate_prescaler dprs_checker #(
    .ADDR_W   (ADDR_W),
    .RATIO_W  (dprs_pkg::RATIO_W),
    .REG_ADDR (REG_ADDR)
) u_dprs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ctrl_bits (8'(ctrl_q)),
    .per_ratio (per_ratio),
    .psc_ratio (psc_ratio),
    .per_clr   (per_clr),
    .psc_clr   (psc_clr),
    .per_tick  (per_tick),
    .psc_tick  (psc_tick),
    .aux_tick  (aux_tick),
    .clk_out   (clk_out),
    .sync_req  (sync_req)
);

// File: tb/test_dual_rate_prescaler.sv
module test_dual_rate_prescaler;

    localparam time CLK_PERIOD = 10ns;
    localparam logic [7:0] REG_ADDR = 8'hF3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       per_tick, psc_tick, aux_tick, clk_out, sync_req;

    int checks = 0;
    int fails  = 0;

    typedef struct packed {
        logic [7:0] rdata;
        logic       pt;
        logic       st;
        logic       at;
        logic       sr;
        logic       co;
    } exp_t;

    exp_t  exp_q[$];
    string ctx_q[$];

    // reference state
    logic [7:0] m_reg = 8'h00;
    int         m_cp  = 0;
    int         m_cs  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_rate_prescaler i_dual_rate_prescaler (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .per_tick  (per_tick),
        .psc_tick  (psc_tick),
        .aux_tick  (aux_tick),
        .clk_out   (clk_out),
        .sync_req  (sync_req)
    );

    function automatic int per_r(input logic [1:0] c);
        return 1 << c;
    endfunction

    function automatic int psc_r(input logic [2:0] c);
        case (c)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 6;
            3'd4: return 8;
            3'd5: return 10;
            3'd6: return 12;
            default: return 16;
        endcase
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] expv,
                       input string what, input string ctx);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s (%s) actual=%h expected=%h", what, ctx, act, expv);
        end
    endtask

    // driver: drive one cycle, push the expected outputs of that cycle
    task automatic step(input logic wr, input logic [7:0] addr,
                        input logic [7:0] data, input string ctx);
        int   rp, rs, rsel, csel;
        exp_t e;
        logic [7:0] nreg;
        @(negedge clk);
        bus_wr    = wr;
        bus_addr  = addr;
        bus_wdata = data;
        rp   = per_r(m_reg[4:3]);
        rs   = psc_r(m_reg[2:0]);
        e.pt = (m_cp == rp - 1);
        e.st = (m_cs == rs - 1);
        e.at = m_reg[6] ? e.pt : e.st;
        e.sr = m_reg[5] & e.at;
        rsel = m_reg[6] ? rp : rs;
        csel = m_reg[6] ? m_cp : m_cs;
        e.co = m_reg[7] && (csel < (rsel + 1) / 2);
        e.rdata = (addr == REG_ADDR) ? m_reg : 8'h00;
        exp_q.push_back(e);
        ctx_q.push_back(ctx);
        nreg = (wr && addr == REG_ADDR) ? data : m_reg;
        m_cp = (nreg[4:3] != m_reg[4:3]) ? 0 : (e.pt ? 0 : m_cp + 1);
        m_cs = (nreg[2:0] != m_reg[2:0]) ? 0 : (e.st ? 0 : m_cs + 1);
        m_reg = nreg;
    endtask

    task automatic idle(input int n, input string ctx);
        for (int k = 0; k < n; k++)
            step(1'b0, (k % 3 == 2) ? 8'h20 : REG_ADDR, 8'hA5, ctx);
    endtask

    // monitor: pop and compare away from the active edge
    always begin
        exp_t  e;
        string c;
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            c = ctx_q.pop_front();
            chk(bus_rdata,       e.rdata,       "R2 bus_rdata", c);
            chk(8'(per_tick),    8'(e.pt),      "R3 per_tick",  c);
            chk(8'(psc_tick),    8'(e.st),      "R4 psc_tick",  c);
            chk(8'(aux_tick),    8'(e.at),      "R5 aux_tick",  c);
            chk(8'(sync_req),    8'(e.sr),      "R6 sync_req",  c);
            chk(8'(clk_out),     8'(e.co),      "R7 clk_out",   c);
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset value and ratio 1 on both dividers
        idle(4, "R1 reset state");
        // sweep every ratio code and control bit combination
        for (int i = 0; i < 8; i++) begin
            step(1'b1, REG_ADDR, {3'(i), 2'(i), 3'(i)}, "R8 ratio change");
            idle(24, "R3 R4 R5 R6 R7 sweep A");
            step(1'b1, REG_ADDR, {~3'(i), 2'(i + 1), 3'(7 - i)}, "R8 ratio change");
            idle(24, "R3 R4 R5 R6 R7 sweep B");
        end
        // R8: change only the prescaler field, peripheral phase kept
        step(1'b1, REG_ADDR, 8'b1101_1101, "R8 setup");
        idle(5, "R8 mid period");
        step(1'b1, REG_ADDR, 8'b1101_1011, "R8 psc only");
        idle(20, "R8 per phase kept");
        // R8: rewrite of an identical value keeps both phases
        idle(3, "R8 mid period");
        step(1'b1, REG_ADDR, 8'b1101_1011, "R8 same value");
        idle(20, "R8 no restart");
        // R2: write elsewhere is ignored
        step(1'b1, 8'h10, 8'hFF, "R2 other address");
        step(1'b1, 8'hF2, 8'h00, "R2 other address");
        idle(12, "R2 register unchanged");
        // R7: ratio 1 on the selected divider holds the pin high
        step(1'b1, REG_ADDR, 8'b1000_0000, "R7 ratio one");
        idle(6, "R7 ratio one pin");
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (2) @(negedge clk);
        #(CLK_PERIOD/2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule